// File: doc/BRIEF.md
# Flash Program/Erase Error-Protection Controller

This block decides, cycle by cycle, whether a flash array may be read and whether it may be programmed or erased. It runs a five-state machine: hardware protection, normal read, program/erase, error lockout and software standby. Each state sets its own read and program/erase permissions. The program/erase interface registers elsewhere in the chip reset themselves whenever the block raises its clear output.

If a flash read of any kind arrives while a program or erase is running, the block locks programming out and raises a sticky error flag. A read of any kind here means a data read, an exception-vector fetch or an instruction fetch. A sleep instruction executed during the operation has the same effect. Ordinary events do not clear the flag. Only power-on reset, the hardware-standby pin or entry into software standby clear it. While the flag is set, reads stay allowed.

All inputs are sampled on the rising clock edge. A decision made from the inputs of one cycle shows on the outputs right after that edge.

Top module: `fp_errprot_ctrl`

## Requirements
- R1: While `por_n` or `hstby_n` is low, this takes priority over every other input, and after the next edge the outputs are `rd_en`=1, `pe_en`=0, `err_flag`=0 and `regs_clr`=1. When both are high, the next edge moves the block to normal read.
- R2: In normal read the outputs are `rd_en`=1, `pe_en`=0, `err_flag`=0 and `regs_clr`=0. `pe_start` moves the block to program/erase on the next edge. If `sstby_req` is also high, `sstby_req` wins.
- R3: In program/erase the outputs are `pe_en`=1, `rd_en`=0 and `err_flag`=0. `pe_done` with no violation in the same cycle returns the block to normal read.
- R4: In program/erase, any set bit of `rd_req` moves the block to error lockout on the next edge. Bit 0 is a data read, bit 1 a vector fetch and bit 2 an instruction fetch. This happens even when `pe_done` is high in the same cycle.
- R5: `sleep_exec` during program/erase moves the block to error lockout on the next edge.
- R6: In error lockout the outputs are `rd_en`=1, `pe_en`=0 and `err_flag`=1. `pe_start`, `pe_done`, `rd_req`, `sleep_exec` and `sstby_cancel` leave all of these unchanged.
- R7: `sstby_req` in error lockout or in normal read moves the block to software standby. There the outputs are `rd_en`=0, `pe_en`=0 and `err_flag`=0. `regs_clr` is high in the first standby cycle only.
- R8: `sstby_cancel` in software standby returns the block to normal read, with `err_flag`=0.
- R9: In normal read, `rd_req` and `sleep_exec` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| hstby_n | input | 1 | Hardware-standby pin, active low |
| pe_start | input | 1 | Request to begin a program or erase |
| pe_done | input | 1 | Program or erase finished |
| rd_req | input | N_RD_SRC | Flash read strobes: bit 0 data read, bit 1 vector fetch, bit 2 instruction fetch |
| sleep_exec | input | 1 | A sleep instruction is executing |
| sstby_req | input | 1 | Enter software standby |
| sstby_cancel | input | 1 | Leave software standby |
| rd_en | output | 1 | Flash reads permitted |
| pe_en | output | 1 | Program/erase permitted |
| err_flag | output | 1 | Sticky error indication |
| regs_clr | output | 1 | Return the program/erase interface registers to their initial state |

## Verification
The bench builds the block with the default `N_RD_SRC` of 3. With that value, each kind of read (data, vector, instruction) can be driven on its own during program/erase and checked as a separate way into error lockout. Random cycles drive the read strobes alone, together with `pe_done`, and together with standby requests. This reaches the priority orderings, such as a violation against completion and standby against start. The state that produces each output pattern never has to be forced.

// File: rtl/fp_errprot_pkg.sv
package fp_errprot_pkg;

    typedef enum logic [2:0] {
        ST_HWPROT  = 3'd0,
        ST_READ    = 3'd1,
        ST_PGM     = 3'd2,
        ST_ERRLOCK = 3'd3,
        ST_SSTBY   = 3'd4
    } fp_state_e;

    typedef struct packed {
        logic rd_en;
        logic pe_en;
    } fp_perm_t;

    function automatic fp_perm_t perm_of(fp_state_e s);
        fp_perm_t p;
        p.rd_en = (s == ST_HWPROT) || (s == ST_READ) || (s == ST_ERRLOCK);
        p.pe_en = (s == ST_PGM);
        return p;
    endfunction

endpackage

// File: rtl/fp_viol_detect.sv
module fp_viol_detect
    import fp_errprot_pkg::*;
#(
    parameter int N_RD_SRC = 3
) (
    input  fp_state_e             st,
    input  logic [N_RD_SRC-1:0]   rd_req,
    input  logic                  sleep_exec,
    output logic                  viol
);
    logic              busy;
    logic [N_RD_SRC:0] hit;

    assign busy = (st == ST_PGM);

    for (genvar i = 0; i < N_RD_SRC; i++) begin : g_src
        assign hit[i] = busy & rd_req[i];
    end
    assign hit[N_RD_SRC] = busy & sleep_exec;

    assign viol = |hit;
endmodule

// File: rtl/fp_state_ctrl.sv
module fp_state_ctrl
    import fp_errprot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hstby_n,
    input  logic      pe_start,
    input  logic      pe_done,
    input  logic      viol,
    input  logic      sstby_req,
    input  logic      sstby_cancel,
    output fp_state_e st,
    output logic      err_flag,
    output logic      regs_clr
);
    fp_state_e nxt;

    always_comb begin
        nxt = st;
        if (!hstby_n) begin
            nxt = ST_HWPROT;
        end else begin
            case (st)
                ST_HWPROT:  nxt = ST_READ;
                ST_READ:    if (sstby_req) nxt = ST_SSTBY;
                            else if (pe_start) nxt = ST_PGM;
                ST_PGM:     if (viol) nxt = ST_ERRLOCK;
                            else if (pe_done) nxt = ST_READ;
                ST_ERRLOCK: if (sstby_req) nxt = ST_SSTBY;
                ST_SSTBY:   if (sstby_cancel) nxt = ST_READ;
                default:    nxt = ST_HWPROT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_HWPROT;
            err_flag <= 1'b0;
            regs_clr <= 1'b1;
        end else begin
            st       <= nxt;
            err_flag <= (nxt == ST_ERRLOCK);
            regs_clr <= (nxt == ST_HWPROT) || ((nxt == ST_SSTBY) && (st != ST_SSTBY));
        end
    end

    // R1: hardware standby overrides everything
    a_r1_hw_priority: assert property (@(posedge clk) disable iff (rst)
        !hstby_n |=> (st == ST_HWPROT && !err_flag && regs_clr));

    // R4/R5: a violation in program/erase raises the flag
    a_r4_viol_locks: assert property (@(posedge clk) disable iff (rst)
        (viol && hstby_n) |=> (err_flag && st == ST_ERRLOCK));

    // R6: the flag holds until standby of either kind
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag && hstby_n && !sstby_req) |=> err_flag);

    // R7: clear pulse lasts a single standby cycle
    a_r7_clr_single: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SSTBY && hstby_n && !sstby_cancel) |=> !regs_clr);

    // R8: leaving standby lands in normal read with the flag low
    a_r8_cancel_read: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SSTBY && hstby_n && sstby_cancel) |=> (st == ST_READ && !err_flag));
endmodule

// File: rtl/fp_errprot_ctrl.sv
module fp_errprot_ctrl
    import fp_errprot_pkg::*;
#(
    parameter int N_RD_SRC = 3
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                hstby_n,
    input  logic                pe_start,
    input  logic                pe_done,
    input  logic [N_RD_SRC-1:0] rd_req,
    input  logic                sleep_exec,
    input  logic                sstby_req,
    input  logic                sstby_cancel,
    output logic                rd_en,
    output logic                pe_en,
    output logic                err_flag,
    output logic                regs_clr
);
    logic      rst;
    logic      viol;
    fp_state_e st;
    fp_perm_t  perm;

    assign rst = !por_n;

    fp_viol_detect #(.N_RD_SRC(N_RD_SRC)) u_viol (
        .st         (st),
        .rd_req     (rd_req),
        .sleep_exec (sleep_exec),
        .viol       (viol)
    );

    fp_state_ctrl u_fsm (
        .clk          (clk),
        .rst          (rst),
        .hstby_n      (hstby_n),
        .pe_start     (pe_start),
        .pe_done      (pe_done),
        .viol         (viol),
        .sstby_req    (sstby_req),
        .sstby_cancel (sstby_cancel),
        .st           (st),
        .err_flag     (err_flag),
        .regs_clr     (regs_clr)
    );

    assign perm  = perm_of(st);
    assign rd_en = perm.rd_en;
    assign pe_en = perm.pe_en;

    // R3: reading and programming are never granted together
    a_r3_perm_excl: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && pe_en));

    // R6: while the flag is set, programming stays locked
    a_r6_lock_pe: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> (!pe_en && rd_en));
endmodule

// File: tb/fp_errprot_ctrl_tb_top.sv
module fp_errprot_ctrl_tb_top;
    localparam int NR = 3;

    logic clk = 1'b0;
    logic por_n, hstby_n, pe_start, pe_done, sleep_exec, sstby_req, sstby_cancel;
    logic [NR-1:0] rd_req;
    logic rd_en, pe_en, err_flag, regs_clr;

    int n_chk = 0;
    int n_bad = 0;
    int mst;   // 0 hw, 1 read, 2 pgm, 3 err, 4 standby
    bit mclr;

    always #4 clk = ~clk;

    fp_errprot_ctrl #(.N_RD_SRC(NR)) dut_i (
        .clk(clk), .por_n(por_n), .hstby_n(hstby_n), .pe_start(pe_start),
        .pe_done(pe_done), .rd_req(rd_req), .sleep_exec(sleep_exec),
        .sstby_req(sstby_req), .sstby_cancel(sstby_cancel),
        .rd_en(rd_en), .pe_en(pe_en), .err_flag(err_flag), .regs_clr(regs_clr)
    );

    function automatic int nxt_model(int s);
        if (!por_n || !hstby_n) return 0;
        case (s)
            0: return 1;
            1: return sstby_req ? 4 : (pe_start ? 2 : 1);
            2: return ((|rd_req) || sleep_exec) ? 3 : (pe_done ? 1 : 2);
            3: return sstby_req ? 4 : 3;
            default: return sstby_cancel ? 1 : 4;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic idle();
        por_n = 1; hstby_n = 1; pe_start = 0; pe_done = 0; rd_req = '0;
        sleep_exec = 0; sstby_req = 0; sstby_cancel = 0;
    endtask

    task automatic cyc(input string tag);
        int ns;
        bit erd, epe, eerr;
        ns = nxt_model(mst);
        mclr = (ns == 0) || (ns == 4 && mst != 4);
        mst = ns;
        @(posedge clk);
        @(negedge clk);
        erd  = (mst == 0) || (mst == 1) || (mst == 3);
        epe  = (mst == 2);
        eerr = (mst == 3);
        n_chk++;
        if (rd_en !== erd || pe_en !== epe || err_flag !== eerr || regs_clr !== mclr) begin
            n_bad++;
            $display("FAIL %s: got rd=%b pe=%b err=%b clr=%b exp rd=%b pe=%b err=%b clr=%b",
                     tag, rd_en, pe_en, err_flag, regs_clr, erd, epe, eerr, mclr);
        end
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        mst = 0; mclr = 1;
        idle();
        @(negedge clk);
        por_n = 0;
        cyc("R1"); cyc("R1");
        por_n = 1;
        cyc("R1");                                    // R1 release to read
        pe_start = 1; cyc("R2"); pe_start = 0;        // R2 start
        pe_done = 1; cyc("R3"); pe_done = 0;          // R3 done
        pe_start = 1; cyc("R2"); pe_start = 0;
        rd_req = 3'b010; cyc("R4"); rd_req = '0;      // R4 vector fetch
        sstby_req = 1; cyc("R7"); sstby_req = 0;      // R7 clr pulse
        cyc("R7");                                    // R7 clr drops
        sstby_cancel = 1; cyc("R8"); sstby_cancel = 0;// R8
        pe_start = 1; cyc("R2"); pe_start = 0;
        rd_req = 3'b001; pe_done = 1; cyc("R4"); rd_req = '0; pe_done = 0;
        pe_start = 1; pe_done = 1; sleep_exec = 1; rd_req = 3'b100;
        sstby_cancel = 1; cyc("R6");                  // R6 ignored inputs
        idle();
        hstby_n = 0; cyc("R1"); hstby_n = 1;          // R1 clears flag
        cyc("R1");
        rd_req = 3'b111; sleep_exec = 1; cyc("R9");   // R9
        cyc("R9"); idle();
        pe_start = 1; cyc("R2"); pe_start = 0;
        rd_req = 3'b100; cyc("R4"); rd_req = '0;      // R4 instruction fetch
        hstby_n = 0; cyc("R1"); hstby_n = 1; cyc("R1");
        pe_start = 1; cyc("R2"); pe_start = 0;
        sleep_exec = 1; cyc("R5"); sleep_exec = 0;    // R5
        sstby_req = 1; pe_start = 1; cyc("R7"); idle();
        sstby_cancel = 1; cyc("R8"); idle();
        sstby_req = 1; pe_start = 1; cyc("R2"); idle(); // R2 standby wins
        sstby_cancel = 1; cyc("R8"); idle();

        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4000; i++) begin
            por_n        = ($urandom() % 64) != 0;
            hstby_n      = ($urandom() % 48) != 0;
            pe_start     = ($urandom() % 3) == 0;
            pe_done      = ($urandom() % 5) == 0;
            rd_req       = (($urandom() % 6) == 0) ? NR'($urandom()) : '0;
            sleep_exec   = ($urandom() % 12) == 0;
            sstby_req    = ($urandom() % 10) == 0;
            sstby_cancel = ($urandom() % 4) == 0;
            cyc(tag_of(nxt_model(mst)));
        end
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule